// File: doc/BRIEF.md
# Legacy Interrupt Controller Initialization Sequencer

This block is the configuration front end of an eight-input legacy interrupt controller. Software reaches it through a byte-wide write bus with a single port-select bit: port 0 is the command port and port 1 is the data port. The block does not resolve priorities or run acknowledge cycles. It tracks the ordered setup handshake and captures the configuration that the rest of the controller needs.

A start word on the command port opens a setup sequence. The next three data-port writes are taken, in order, as the vector base, the cascade byte and the mode byte. The cascade byte is the secondary-attached input map on a primary unit, or the unit's own identity on a secondary unit. Once the mode byte is accepted, the unit reports itself ready, and each later data-port write replaces the 8-bit interrupt mask. A combinational lookup turns an input index into the vector that would be delivered for that input.

Top module: `pic_init_seq`

## Requirements
- R1: After synchronous reset, init_done is 0, mask_out is 0xFF, and vec_base_out, cascade_out and mode_out are 0x00.
- R2: A write of 0x11 with wr_port=0 (command port) is the start word. In any state it clears mask_out to 0x00 and drops init_done on the next clock edge.
- R3: The first data-port write (wr_port=1) after a start word loads vec_base_out.
- R4: The second data-port write after a start word loads cascade_out.
- R5: The third data-port write after a start word loads mode_out, and init_done goes high on that same edge. init_done is never high otherwise.
- R6: While init_done is high, each data-port write loads mask_out, and the captured base, cascade and mode stay unchanged. A mask of 0xFF masks all eight inputs.
- R7: Command-port writes of any value other than 0x11 change no output.
- R8: Data-port writes made before any start word since reset change no output.
- R9: A start word received partway through a sequence restarts it, so the next data-port write loads vec_base_out again.
- R10: irq_vector equals vec_base_out with its low three bits replaced by irq_idx. It is combinational.
- R11: A cycle with wr_en=0 leaves every registered output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_port | input | 1 | 0 = command port, 1 = data port |
| wr_data | input | 8 | Write byte |
| irq_idx | input | 3 | Input index for the vector lookup |
| vec_base_out | output | 8 | Captured vector base |
| cascade_out | output | 8 | Captured cascade byte |
| mode_out | output | 8 | Captured mode byte |
| mask_out | output | 8 | Current interrupt mask |
| init_done | output | 1 | High once the mode byte has been accepted |
| irq_vector | output | 8 | Vector for input irq_idx |

## Verification
On every cycle, the assertions check four things: a start word clears the mask and drops init_done, init_done rises only on a data write, idle cycles and non-start command writes leave the outputs stable, and the delivered vector keeps the base's upper bits. Only the bench's ordered scenarios can show a few other behaviours. These are that each data write lands in the field that matches its place in the sequence, that a restart partway through returns to the base step, and that data writes before any start word are discarded.

// File: rtl/pic_init_pkg.sv
package pic_init_pkg;

    localparam int BYTE_W     = 8;
    localparam int NUM_INPUTS = 8;
    localparam logic [BYTE_W-1:0] START_WORD = 8'h11;

    typedef enum logic [2:0] {
        ST_UNINIT,
        ST_BASE,
        ST_CASC,
        ST_MODE,
        ST_READY
    } seq_state_e;

    typedef struct packed {
        logic ld_base;
        logic ld_casc;
        logic ld_mode;
        logic ld_mask;
        logic clr_mask;
    } load_ctl_t;

    function automatic logic [BYTE_W-1:0] merge_vector(
        input logic [BYTE_W-1:0] base,
        input logic [BYTE_W-1:0] idx_ext,
        input int                idx_w
    );
        logic [BYTE_W-1:0] keep;
        keep = {BYTE_W{1'b1}} << idx_w;
        return (base & keep) | (idx_ext & ~keep);
    endfunction

endpackage

// File: rtl/pic_seq_fsm.sv
module pic_seq_fsm
    import pic_init_pkg::*;
#(
    parameter int DATA_W = BYTE_W,
    parameter logic [DATA_W-1:0] START = START_WORD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_port,
    input  logic [DATA_W-1:0] wr_data,
    output load_ctl_t         ctl,
    output logic              ready
);

    seq_state_e state_q, state_d;
    logic is_start, is_data;

    always_comb begin
        is_start = wr_en && !wr_port && (wr_data == START);
        is_data  = wr_en && wr_port;
    end

    always_comb begin
        state_d = state_q;
        ctl     = '0;
        if (is_start) begin
            state_d      = ST_BASE;
            ctl.clr_mask = 1'b1;
        end else if (is_data) begin
            unique case (state_q)
                ST_BASE:  begin ctl.ld_base = 1'b1; state_d = ST_CASC;  end
                ST_CASC:  begin ctl.ld_casc = 1'b1; state_d = ST_MODE;  end
                ST_MODE:  begin ctl.ld_mode = 1'b1; state_d = ST_READY; end
                ST_READY: ctl.ld_mask = 1'b1;
                default:  state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_UNINIT;
        else     state_q <= state_d;
    end

    assign ready = (state_q == ST_READY);

    AST_READY_ON_DATA: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(wr_en && wr_port)); // R5

endmodule

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
    import pic_init_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  load_ctl_t         ctl,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] base_q,
    output logic [DATA_W-1:0] casc_q,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            casc_q <= '0;
            mode_q <= '0;
            mask_q <= '1;
        end else begin
            if (ctl.ld_base)  base_q <= wr_data;
            if (ctl.ld_casc)  casc_q <= wr_data;
            if (ctl.ld_mode)  mode_q <= wr_data;
            if (ctl.clr_mask) mask_q <= '0;
            else if (ctl.ld_mask) mask_q <= wr_data;
        end
    end

endmodule

// File: rtl/pic_vector_map.sv
module pic_vector_map
    import pic_init_pkg::*;
#(
    parameter int DATA_W = BYTE_W,
    parameter int IDX_W  = 3
) (
    input  logic [DATA_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] vector
);

    localparam int PAD_W = DATA_W - IDX_W;

    generate
        if (PAD_W > 0) begin : g_merge
            assign vector = merge_vector(base, {{PAD_W{1'b0}}, idx}, IDX_W);
        end else begin : g_full
            assign vector = idx[DATA_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_init_pkg::*;
#(
    parameter int DATA_W = BYTE_W,
    parameter int INPUTS = NUM_INPUTS,
    parameter logic [DATA_W-1:0] START = START_WORD,
    localparam int IDX_W = $clog2(INPUTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_port,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  irq_idx,
    output logic [DATA_W-1:0] vec_base_out,
    output logic [DATA_W-1:0] cascade_out,
    output logic [DATA_W-1:0] mode_out,
    output logic [DATA_W-1:0] mask_out,
    output logic              init_done,
    output logic [DATA_W-1:0] irq_vector
);

    load_ctl_t ctl;

    pic_seq_fsm #(.DATA_W(DATA_W), .START(START)) u_fsm (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_port(wr_port),
        .wr_data(wr_data), .ctl(ctl), .ready(init_done)
    );

    pic_cfg_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .ctl(ctl), .wr_data(wr_data),
        .base_q(vec_base_out), .casc_q(cascade_out),
        .mode_q(mode_out), .mask_q(mask_out)
    );

    pic_vector_map #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_vmap (
        .base(vec_base_out), .idx(irq_idx), .vector(irq_vector)
    );

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_port && wr_data == START) |=> (mask_out == '0 && !init_done)); // R2

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(mask_out) && $stable(vec_base_out) && $stable(cascade_out)
                    && $stable(mode_out) && $stable(init_done))); // R11

    AST_OTHER_CMD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_port && wr_data != START) |=> ($stable(mask_out) && $stable(vec_base_out)
            && $stable(cascade_out) && $stable(mode_out) && $stable(init_done))); // R7

    AST_VECTOR_UPPER: assert property (@(posedge clk) disable iff (rst)
        irq_vector[DATA_W-1:IDX_W] == vec_base_out[DATA_W-1:IDX_W]); // R10

endmodule

// File: tb/pic_init_seq_bench.sv
module pic_init_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NSTEP = 17;
    // entry: req[4] en[1] port[1] data[8] | done[1] base[8] casc[8] mode[8] mask[8]
    localparam logic [46:0] STEPS [NSTEP] = '{
        {4'd8,  1'b1, 1'b1, 8'h55, 1'b0, 8'h00, 8'h00, 8'h00, 8'hFF}, // R8
        {4'd7,  1'b1, 1'b0, 8'h20, 1'b0, 8'h00, 8'h00, 8'h00, 8'hFF}, // R7
        {4'd2,  1'b1, 1'b0, 8'h11, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00}, // R2
        {4'd3,  1'b1, 1'b1, 8'h20, 1'b0, 8'h20, 8'h00, 8'h00, 8'h00}, // R3
        {4'd11, 1'b0, 1'b1, 8'h77, 1'b0, 8'h20, 8'h00, 8'h00, 8'h00}, // R11
        {4'd4,  1'b1, 1'b1, 8'h04, 1'b0, 8'h20, 8'h04, 8'h00, 8'h00}, // R4
        {4'd5,  1'b1, 1'b1, 8'h01, 1'b1, 8'h20, 8'h04, 8'h01, 8'h00}, // R5
        {4'd6,  1'b1, 1'b1, 8'hFF, 1'b1, 8'h20, 8'h04, 8'h01, 8'hFF}, // R6
        {4'd6,  1'b1, 1'b1, 8'hA5, 1'b1, 8'h20, 8'h04, 8'h01, 8'hA5}, // R6
        {4'd7,  1'b1, 1'b0, 8'h0B, 1'b1, 8'h20, 8'h04, 8'h01, 8'hA5}, // R7
        {4'd2,  1'b1, 1'b0, 8'h11, 1'b0, 8'h20, 8'h04, 8'h01, 8'h00}, // R2
        {4'd3,  1'b1, 1'b1, 8'h28, 1'b0, 8'h28, 8'h04, 8'h01, 8'h00}, // R3
        {4'd9,  1'b1, 1'b0, 8'h11, 1'b0, 8'h28, 8'h04, 8'h01, 8'h00}, // R9
        {4'd9,  1'b1, 1'b1, 8'h30, 1'b0, 8'h30, 8'h04, 8'h01, 8'h00}, // R9
        {4'd4,  1'b1, 1'b1, 8'h02, 1'b0, 8'h30, 8'h02, 8'h01, 8'h00}, // R4
        {4'd5,  1'b1, 1'b1, 8'h01, 1'b1, 8'h30, 8'h02, 8'h01, 8'h00}, // R5
        {4'd6,  1'b1, 1'b1, 8'h00, 1'b1, 8'h30, 8'h02, 8'h01, 8'h00}  // R6
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_port = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] irq_idx = '0;
    logic [7:0] vec_base_out, cascade_out, mode_out, mask_out, irq_vector;
    logic       init_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_init_seq u_pic_init_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
        .irq_idx(irq_idx), .vec_base_out(vec_base_out), .cascade_out(cascade_out),
        .mode_out(mode_out), .mask_out(mask_out), .init_done(init_done),
        .irq_vector(irq_vector)
    );

    task automatic check_state(input int req, input logic done, input logic [7:0] base,
                               input logic [7:0] casc, input logic [7:0] mode,
                               input logic [7:0] mask);
        checks++;
        if (init_done !== done || vec_base_out !== base || cascade_out !== casc ||
            mode_out !== mode || mask_out !== mask) begin
            errors++;
            $display("FAIL R%0d: got done=%0b base=%h casc=%h mode=%h mask=%h, expected done=%0b base=%h casc=%h mode=%h mask=%h",
                     req, init_done, vec_base_out, cascade_out, mode_out, mask_out,
                     done, base, casc, mode, mask);
        end
    endtask

    task automatic check_vec(input logic [2:0] idx, input logic [7:0] exp);
        irq_idx = idx;
        #1;
        checks++;
        if (irq_vector !== exp) begin
            errors++;
            $display("FAIL R10: idx=%0d got %h expected %h", idx, irq_vector, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_state(1, 1'b0, 8'h00, 8'h00, 8'h00, 8'hFF); // R1 reset state
        for (int i = 0; i < NSTEP; i++) begin
            wr_en   = STEPS[i][42];
            wr_port = STEPS[i][41];
            wr_data = STEPS[i][40:33];
            @(negedge clk);
            check_state(int'(STEPS[i][46:43]), STEPS[i][32], STEPS[i][31:24],
                        STEPS[i][23:16], STEPS[i][15:8], STEPS[i][7:0]);
        end
        wr_en = 1'b0;
        // R10: vector lookup with base 0x30
        check_vec(3'd0, 8'h30);
        check_vec(3'd5, 8'h35);
        check_vec(3'd7, 8'h37);
        // R1: reset after configuration returns the reset state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_state(1, 1'b0, 8'h00, 8'h00, 8'h00, 8'hFF);
        check_vec(3'd6, 8'h06); // R10 with zero base
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule